// File: doc/BRIEF.md
# Split-Carry Loadable Up/Down Counter

This block is a 16-bit synchronous binary counter that can count up or down, take a parallel load and be cleared at any time. Inside, it is built as two 8-bit halves. In each half the counting carry passes through a chain of 2-bit groups. Each group works out its own outgoing carry from three things: the carry coming in, the count direction and its two current bits.

The upper half has a register enable of its own. That enable is the lower half's terminal carry ORed with the load request, so the upper half's carry chain is only as long as one byte. A load still reaches all sixteen bits in every cycle. Seen from its ports, the counter behaves exactly like a plain 16-bit up/down counter that wraps modulo 65536. A terminal-carry output tells a neighbouring stage when the next enabled edge will wrap the count.

Top module: `updn_split_counter`

## Requirements
- R1: While `rst` is high, `count` is 0x0000. The clear takes effect without a clock edge and overrides both load and counting.
- R2: When `cntEn`=1, `loadReq`=0 and `countUp`=1, each rising edge adds one to `count`, and 0xFFFF wraps to 0x0000.
- R3: When `cntEn`=1, `loadReq`=0 and `countUp`=0, each rising edge subtracts one from `count`, and 0x0000 wraps to 0xFFFF.
- R4: When `cntEn`=0 and `loadReq`=0, `count` holds its value across the edge.
- R5: When `loadReq`=1, the edge copies all 16 bits of `loadData` into `count`, whatever `cntEn` and `countUp` are.
- R6: A load sets the upper byte `count[15:8]` even when the lower byte is not at its carry value (0xFF going up, 0x00 going down).
- R7: With `loadReq`=0, `count[15:8]` changes only on an edge where `cntEn`=1 and the lower byte is 0xFF while counting up, or 0x00 while counting down.
- R8: `termCarry` is high exactly when `cntEn`=1 and `count` is 0xFFFF with `countUp`=1, or 0x0000 with `countUp`=0. It follows the inputs without a clock.
- R9: At the byte boundary the direction takes effect immediately: from 0x00FF an up count gives 0x0100 and a down count gives 0x00FE, and from 0x0100 a down count gives 0x00FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Asynchronous clear, active high |
| cntEn | input | 1 | Count enable, active high |
| loadReq | input | 1 | Parallel load request, active high |
| countUp | input | 1 | Direction: 1 counts up, 0 counts down |
| loadData | input | 16 | Value captured on a load |
| count | output | 16 | Current count |
| termCarry | output | 1 | Wrap on next enabled edge |

## Verification
The bench runs full sweeps over all 65536 values in both directions, so every group carry and both byte wraps are exercised. A wrong group carry term would skip or repeat values at some multiple of four, and a broken upper-half enable would freeze or double-step the high byte at 0x00FF/0x0100. Loads are issued with the lower byte away from its carry value and with counting disabled. If load were left out of the upper enable, the high byte would keep its old value. Random phases mix direction flips, loads and mid-cycle resets against an arithmetic model, and they catch a terminal carry that ignores direction or enable.

// File: rtl/splitcnt_pkg.sv
`timescale 1ns/1ps
package splitcnt_pkg;
  // Strobes from control to datapath
  typedef struct packed {
    logic loadSel;   // take parallel data
    logic lowEn;     // lower half register enable
    logic upDir;     // direction for every group carry
    logic chainIn;   // carry into the first group of each half
  } cntStrobes_t;
endpackage

// File: rtl/splitcnt_half.sv
`timescale 1ns/1ps
module splitcnt_half #(
  parameter int SEG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             regEn,
  input  logic             load,
  input  logic             up,
  input  logic             carryIn,
  input  logic [SEG_W-1:0] dIn,
  output logic [SEG_W-1:0] q,
  output logic             carryOut
);
  localparam int GROUPS = SEG_W / 2;

  logic [GROUPS:0]  grpCarry;
  logic [SEG_W-1:0] toggle;

  assign grpCarry[0] = carryIn;

  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    logic lsb, msb;
    assign lsb = q[2*g];
    assign msb = q[2*g+1];
    // low bit of a group flips whenever a carry arrives
    assign toggle[2*g]   = grpCarry[g];
    // carry toward the group's upper bit
    assign toggle[2*g+1] = grpCarry[g] & (up ? lsb : ~lsb);
    // carry toward the next group
    assign grpCarry[g+1] = grpCarry[g] & (up ? (lsb & msb) : ~(lsb | msb));
  end

  assign carryOut = grpCarry[GROUPS];

  always_ff @(posedge clk or posedge rst) begin
    if (rst)        q <= '0;
    else if (regEn) q <= load ? dIn : (q ^ toggle);
  end
endmodule

// File: rtl/splitcnt_datapath.sv
`timescale 1ns/1ps
module splitcnt_datapath
  import splitcnt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  cntStrobes_t      strobes,
  input  logic [WIDTH-1:0] dIn,
  output logic [WIDTH-1:0] count,
  output logic             termCarry
);
  localparam int SEG_W = WIDTH / 2;

  logic lowCarry, highCarry, highEn;

  // upper half moves on a lower-half carry or on any load
  assign highEn = lowCarry | strobes.loadSel;

  splitcnt_half #(.SEG_W(SEG_W)) uLow (
    .clk(clk), .rst(rst), .regEn(strobes.lowEn), .load(strobes.loadSel),
    .up(strobes.upDir), .carryIn(strobes.chainIn),
    .dIn(dIn[SEG_W-1:0]), .q(count[SEG_W-1:0]), .carryOut(lowCarry)
  );

  // upper chain restarts from the enable, gated by its own register enable
  splitcnt_half #(.SEG_W(SEG_W)) uHigh (
    .clk(clk), .rst(rst), .regEn(highEn), .load(strobes.loadSel),
    .up(strobes.upDir), .carryIn(strobes.chainIn),
    .dIn(dIn[WIDTH-1:SEG_W]), .q(count[WIDTH-1:SEG_W]), .carryOut(highCarry)
  );

  assign termCarry = lowCarry & highCarry;
endmodule

// File: rtl/splitcnt_ctrl.sv
`timescale 1ns/1ps
module splitcnt_ctrl
  import splitcnt_pkg::*;
(
  input  logic        cntEn,
  input  logic        loadReq,
  input  logic        countUp,
  output cntStrobes_t strobes
);
  always_comb begin
    strobes.loadSel = loadReq;
    strobes.lowEn   = cntEn | loadReq;
    strobes.upDir   = countUp;
    strobes.chainIn = cntEn;
  end
endmodule

// File: rtl/updn_split_counter.sv
`timescale 1ns/1ps
module updn_split_counter
  import splitcnt_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cntEn,
  input  logic             loadReq,
  input  logic             countUp,
  input  logic [WIDTH-1:0] loadData,
  output logic [WIDTH-1:0] count,
  output logic             termCarry
);
  cntStrobes_t strobes;

  splitcnt_ctrl uCtrl (
    .cntEn(cntEn), .loadReq(loadReq), .countUp(countUp), .strobes(strobes)
  );

  splitcnt_datapath #(.WIDTH(WIDTH)) uData (
    .clk(clk), .rst(rst), .strobes(strobes), .dIn(loadData),
    .count(count), .termCarry(termCarry)
  );
endmodule

// File: rtl/splitcnt_checker.sv
`timescale 1ns/1ps
module splitcnt_checker #(
  parameter int WIDTH = 16
) (
  input logic             clk,
  input logic             rst,
  input logic             cntEn,
  input logic             loadReq,
  input logic             countUp,
  input logic [WIDTH-1:0] loadData,
  input logic [WIDTH-1:0] count,
  input logic             termCarry
);
  localparam int SEG_W = WIDTH / 2;
  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  always @(posedge clk) begin
    if (rst) AST_RESET_CLEAR: assert (count == '0) else $error("reset value"); // R1
  end

  always @(negedge clk) begin
    if (!rst)
      AST_TERM_CARRY: assert (termCarry == (cntEn && (countUp ? (&count) : (count == '0))))
        else $error("terminal carry"); // R8
  end

  AST_UP_STEP: assert property (@(posedge clk) disable iff (rst)
    (cntEn && !loadReq && countUp) |=> count == $past(count) + ONE); // R2

  AST_DOWN_STEP: assert property (@(posedge clk) disable iff (rst)
    (cntEn && !loadReq && !countUp) |=> count == $past(count) - ONE); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!cntEn && !loadReq) |=> $stable(count)); // R4

  AST_LOAD_ALL: assert property (@(posedge clk) disable iff (rst)
    loadReq |=> count == $past(loadData)); // R5

  AST_HIGH_GATED: assert property (@(posedge clk) disable iff (rst)
    (!loadReq && !(cntEn && (countUp ? (&count[SEG_W-1:0]) : (count[SEG_W-1:0] == '0))))
      |=> $stable(count[WIDTH-1:SEG_W])); // R7
endmodule

bind updn_split_counter splitcnt_checker #(.WIDTH(WIDTH)) uChk (
  .clk(clk), .rst(rst), .cntEn(cntEn), .loadReq(loadReq), .countUp(countUp),
  .loadData(loadData), .count(count), .termCarry(termCarry)
);

// File: tb/sim_updn_split_counter.sv
`timescale 1ns/1ps
module sim_updn_split_counter;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cntEn = 1'b0, loadReq = 1'b0, countUp = 1'b1;
  logic [15:0] loadData = '0;
  logic [15:0] count;
  logic        termCarry;

  int          nTests = 0, nFail = 0;
  logic [15:0] model = '0;
  bit          finished = 0;

  always #4 clk = ~clk;  // 125 MHz

  updn_split_counter u0 (
    .clk(clk), .rst(rst), .cntEn(cntEn), .loadReq(loadReq), .countUp(countUp),
    .loadData(loadData), .count(count), .termCarry(termCarry)
  );

  task automatic check16(input string req, input logic [15:0] act, input logic [15:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic check1(input string req, input logic act, input logic exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic drive(input logic ce, input logic pe, input logic up, input logic [15:0] d);
    cntEn = ce; loadReq = pe; countUp = up; loadData = d;
  endtask

  // checks terminal carry, clocks once, updates model and checks count
  task automatic stepChk(input string req);
    logic expT;
    #1;
    expT = cntEn && (countUp ? (model == 16'hFFFF) : (model == 16'h0000));
    check1("R8 terminal carry", termCarry, expT);
    if (loadReq)     model = loadData;
    else if (cntEn)  model = countUp ? model + 16'd1 : model - 16'd1;
    @(posedge clk); #2;
    check16(req, count, model);
  endtask

  task automatic loadTo(input logic [15:0] v);
    drive(1'b0, 1'b1, 1'b1, v);
    stepChk("R5 load");
  endtask

  initial begin
    #(190000 * 8);
    if (!finished) begin
      nFail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

  initial begin
    // R1: reset with load and count requested
    drive(1'b1, 1'b1, 1'b1, 16'hBEEF);
    repeat (3) @(posedge clk);
    #2 check16("R1 reset holds zero", count, 16'h0000);
    drive(1'b0, 1'b0, 1'b1, 16'h0000);
    #2 rst = 1'b0;
    @(posedge clk); #2;
    check16("R4 idle after reset", count, 16'h0000);

    // R2: full up sweep with wrap
    drive(1'b1, 1'b0, 1'b1, 16'h0000);
    for (int i = 0; i < 65536; i++) stepChk("R2 up count");
    check16("R2 wrap to zero", count, 16'h0000);

    // R3: full down sweep, first step wraps
    drive(1'b1, 1'b0, 1'b0, 16'h0000);
    stepChk("R3 down wrap");
    check16("R3 wrap to ffff", count, 16'hFFFF);
    for (int i = 0; i < 65535; i++) stepChk("R3 down count");

    // R4: hold with enable low
    drive(1'b0, 1'b0, 1'b1, 16'h1234);
    for (int i = 0; i < 4; i++) stepChk("R4 hold");
    drive(1'b0, 1'b0, 1'b0, 16'h1234);
    stepChk("R4 hold down");

    // R5/R6: loads with lower byte away from carry value
    loadTo(16'hAB12);
    check16("R6 upper byte loaded", count, 16'hAB12);
    drive(1'b1, 1'b1, 1'b0, 16'h5634);
    stepChk("R6 load over down count");
    drive(1'b1, 1'b1, 1'b1, 16'hFF00);
    stepChk("R5 load beats count");

    // R9: direction at byte boundary
    loadTo(16'h00FF);
    drive(1'b1, 1'b0, 1'b1, 16'h0);
    stepChk("R9 00ff up");
    check16("R9 gives 0100", count, 16'h0100);
    drive(1'b1, 1'b0, 1'b0, 16'h0);
    stepChk("R9 0100 down");
    check16("R9 gives 00ff", count, 16'h00FF);
    stepChk("R9 00ff down");
    check16("R9 gives 00fe", count, 16'h00FE);

    // random mix with R7 gate checks and mid-cycle resets
    for (int i = 0; i < 6000; i++) begin
      logic [7:0] prevHi;
      logic carryCond;
      if (($urandom % 400) == 0) begin
        rst = 1'b1; #1;
        model = '0;
        check16("R1 async clear", count, 16'h0000);
        @(posedge clk); #2;
        check16("R1 clear held", count, 16'h0000);
        rst = 1'b0;
      end
      drive(($urandom % 4) != 0, ($urandom % 24) == 0,
            (($urandom % 8) == 0) ? ~countUp : countUp,
            (($urandom % 3) == 0) ? {8'($urandom), 8'hFF} : 16'($urandom));
      prevHi = model[15:8];
      carryCond = cntEn && (countUp ? (model[7:0] == 8'hFF) : (model[7:0] == 8'h00));
      stepChk("R7 random model");
      if (!loadReq && !carryCond)
        check16("R7 upper byte stable", {8'h0, count[15:8]}, {8'h0, prevHi});
    end

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end
endmodule